// File: doc/BRIEF.md
# Posted Line Write Buffer with Associative Lookup

This block sits between requesters and a single memory port. It takes whole or partial cache-line writes into a small store of line entries and sends them to memory in the background. Reads are not held behind those writes. Every address that arrives is compared at line granularity against all occupied entries. A write to a line that is already held merges into that entry. A read that misses goes straight to memory, ahead of any older buffered writes.

A read that hits is handled according to its requester class. A processor read that hits a fully written line gets its data from the buffer, and memory is not touched. An inbound I/O read that hits causes the held line to be written to memory first, and the read is then issued to memory. A processor read that hits a line holding only some of its bytes is handled the same way as an inbound hit, so a response never carries bytes that were never written. Any access that conflicts with another on the same line stays in arrival order. If a read and a write are accepted in the same cycle, the read counts as the older of the two.

Top module: `wbuf_cam`

## Requirements
- R1: After reset the buffer holds no entry, `wr_ready` and `rd_ready` are high, `mem_req_valid` is low and `rd_rsp_valid` is low.
- R2: A processor read (`rd_src` = 0) that hits a line whose bytes are all written returns that data with `rd_rsp_hit` = 1 on the cycle after acceptance, and issues no memory request.
- R3: A write to a line already held updates only the bytes whose `wr_be` bit is set. It takes no new entry, so it is accepted even while every entry is occupied.
- R4: When every entry is occupied and the write line matches none of them, `wr_ready` is low.
- R5: A read that misses is sent to memory as a read request (`mem_req_write` = 0) before older buffered writes to other lines. Its response has `rd_rsp_hit` = 0 and carries the memory data.
- R6: An inbound read (`rd_src` = 1) that hits causes a memory write of that line with its accumulated byte mask, then a memory read of the same line. The response comes from memory with `rd_rsp_hit` = 0.
- R7: A processor read that hits a line with any unwritten byte is treated as in R6. The flush write carries only the written bytes in `mem_req_be` (bit b covers data bits 8b+7..8b).
- R8: Buffered lines leave for memory oldest allocation first, one line per memory write request.
- R9: The forced write for a read hit is issued before any background write, even when older lines are waiting.
- R10: A write accepted after a read to the same line does not change that read's data. The read request reaches memory before the write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_line | input | LADDR_W | Line address of the write |
| wr_data | input | LINE_BYTES*8 | Write data for the whole line |
| wr_be | input | LINE_BYTES | Byte enables, at least one set |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read accepted when high together with rd_valid |
| rd_line | input | LADDR_W | Line address of the read |
| rd_src | input | 1 | Requester class: 0 processor, 1 inbound I/O |
| rd_rsp_valid | output | 1 | One-cycle read response strobe |
| rd_rsp_data | output | LINE_BYTES*8 | Read response line |
| rd_rsp_hit | output | 1 | 1 when the response came from the buffer |
| mem_req_valid | output | 1 | Memory request offered this cycle |
| mem_req_ready | input | 1 | Memory takes the offered request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_line | output | LADDR_W | Line address of the request |
| mem_req_data | output | LINE_BYTES*8 | Write data |
| mem_req_be | output | LINE_BYTES | Write byte mask, zero for reads |
| mem_rsp_valid | input | 1 | Read data returning from memory |
| mem_rsp_data | input | LINE_BYTES*8 | Returned line |

## Verification
The bench holds the memory port closed while it fills the buffer, so it knows exactly what is held when each read arrives. It then logs the order of memory requests. An inbound hit is made on a line that is younger than another held line. A design with a wrong priority would write the older line first, and one that skipped the flush would return stale memory data. A read miss is left stalled while a write to the same line is accepted. A design that let the write reach memory first, or forwarded it, would return the new data instead of the old. The bench also fills all sixteen entries to probe the stall. It checks that a merging write still gets in and that lines drain in allocation order, and it reads a partially written line, which a naive forwarder would return with garbage bytes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   // read-side sequencer states
   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_FLUSH = 2'd1,
      RD_MEMRD = 2'd2,
      RD_WAIT  = 2'd3
   } rd_st_e;

   // requester class on the read port
   localparam logic SRC_CPU = 1'b0;
   localparam logic SRC_IO  = 1'b1;

endpackage

// File: rtl/wbuf_cam_match.sv
// Associative compare of one key against every occupied entry tag.
module wbuf_cam_match #(
   parameter int N  = 16,
   parameter int AW = 26,
   parameter int IW = 4
) (
   input  logic [N-1:0]         vld,
   input  logic [N-1:0][AW-1:0] tags,
   input  logic [AW-1:0]        key,
   output logic [N-1:0]         hit,
   output logic                 any,
   output logic [IW-1:0]        idx
);

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = vld[i] && (tags[i] == key);
   end

   assign any = |hit;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (hit[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/wbuf_age.sv
// Age matrix: tracks allocation order among entries and names the oldest one.
module wbuf_age #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  vld,
   input  logic [N-1:0]  alloc,
   output logic [N-1:0]  oldest,
   output logic          any,
   output logic [IW-1:0] idx
);

   // before_q[i][j] set: entry i was allocated earlier than entry j
   logic [N-1:0][N-1:0] before_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         before_q <= '0;
      end else begin
         for (int k = 0; k < N; k++) begin
            if (alloc[k]) begin
               for (int i = 0; i < N; i++) begin
                  before_q[k][i] <= 1'b0;
                  before_q[i][k] <= (i != k);
               end
            end
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_old
      logic [N-1:0] elder;
      for (genvar j = 0; j < N; j++) begin : g_col
         assign elder[j] = before_q[j][i];
      end
      assign oldest[i] = vld[i] && !(|(elder & vld));
   end

   assign any = |oldest;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (oldest[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/wbuf_cam.sv
module wbuf_cam
   import wbuf_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int LINE_BYTES = 64,
   parameter int LADDR_W    = 26
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_valid,
   output logic                    wr_ready,
   input  logic [LADDR_W-1:0]      wr_line,
   input  logic [LINE_BYTES*8-1:0] wr_data,
   input  logic [LINE_BYTES-1:0]   wr_be,
   input  logic                    rd_valid,
   output logic                    rd_ready,
   input  logic [LADDR_W-1:0]      rd_line,
   input  logic                    rd_src,
   output logic                    rd_rsp_valid,
   output logic [LINE_BYTES*8-1:0] rd_rsp_data,
   output logic                    rd_rsp_hit,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic                    mem_req_write,
   output logic [LADDR_W-1:0]      mem_req_line,
   output logic [LINE_BYTES*8-1:0] mem_req_data,
   output logic [LINE_BYTES-1:0]   mem_req_be,
   input  logic                    mem_rsp_valid,
   input  logic [LINE_BYTES*8-1:0] mem_rsp_data
);

   localparam int IW = $clog2(ENTRIES);
   localparam int LW = LINE_BYTES * 8;

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("wbuf_cam: ENTRIES must be at least 2");
   end
   if (LINE_BYTES < 1) begin : g_bad_line
      $error("wbuf_cam: LINE_BYTES must be at least 1");
   end
   if (LADDR_W < 1) begin : g_bad_addr
      $error("wbuf_cam: LADDR_W must be at least 1");
   end

   // entry storage
   logic [ENTRIES-1:0]              vld_q;
   logic [ENTRIES-1:0][LADDR_W-1:0] tag_q;
   logic [LW-1:0]                   data_q [ENTRIES];
   logic [LINE_BYTES-1:0]           mask_q [ENTRIES];

   // read sequencer
   rd_st_e             st_q;
   logic [LADDR_W-1:0] line_q;
   logic [IW-1:0]      fl_idx_q;

   // lookups
   logic [ENTRIES-1:0] w_hit, r_hit, o_vec, alloc_vec;
   logic               w_any, r_any, o_any;
   logic [IW-1:0]      w_idx, r_idx, o_idx, free_idx, emit_idx, wsel;
   logic               full, rd_acc, r_full, rd_fwd, rd_flush;
   logic               drain_ok, drain_fire, flush_fire, emit_fire;
   logic               wr_hold, wr_fire;

   wbuf_cam_match #(.N(ENTRIES), .AW(LADDR_W), .IW(IW)) u_wr_cam (
      .vld(vld_q), .tags(tag_q), .key(wr_line),
      .hit(w_hit), .any(w_any), .idx(w_idx)
   );

   wbuf_cam_match #(.N(ENTRIES), .AW(LADDR_W), .IW(IW)) u_rd_cam (
      .vld(vld_q), .tags(tag_q), .key(rd_line),
      .hit(r_hit), .any(r_any), .idx(r_idx)
   );

   wbuf_age #(.N(ENTRIES), .IW(IW)) u_age (
      .clk(clk), .rst(rst), .vld(vld_q), .alloc(alloc_vec),
      .oldest(o_vec), .any(o_any), .idx(o_idx)
   );

   // lowest free slot
   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld_q[i]) free_idx = IW'(i);
      end
   end

   assign full     = &vld_q;
   assign rd_ready = (st_q == RD_IDLE);
   assign rd_acc   = rd_valid && rd_ready;
   assign r_full   = r_any && (&mask_q[r_idx]);
   assign rd_fwd   = rd_acc && (rd_src == SRC_CPU) && r_full;
   assign rd_flush = rd_acc && r_any && !rd_fwd;

   // background drain only while the read side leaves the port alone
   assign drain_ok   = ((st_q == RD_IDLE) && !rd_valid) || (st_q == RD_WAIT);
   assign drain_fire = drain_ok && o_any && mem_req_ready;
   assign flush_fire = (st_q == RD_FLUSH) && mem_req_ready;
   assign emit_fire  = drain_fire || flush_fire;
   assign emit_idx   = (st_q == RD_FLUSH) ? fl_idx_q : o_idx;

   // a write may not merge into a line that is leaving or is marked for a flush
   assign wr_hold = w_any && ((emit_fire && (w_idx == emit_idx)) ||
                              ((st_q == RD_FLUSH) && (w_idx == fl_idx_q)) ||
                              (rd_flush && (r_idx == w_idx)));
   assign wr_ready  = !wr_hold && (w_any || !full);
   assign wr_fire   = wr_valid && wr_ready;
   assign wsel      = w_any ? w_idx : free_idx;
   assign alloc_vec = (wr_fire && !w_any) ? (ENTRIES'(1) << free_idx) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else begin
         if (emit_fire) vld_q[emit_idx] <= 1'b0;
         if (wr_fire && !w_any) vld_q[free_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fire) begin
         tag_q[wsel]  <= wr_line;
         mask_q[wsel] <= (w_any ? mask_q[wsel] : '0) | wr_be;
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (wr_be[b]) data_q[wsel][b*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q         <= RD_IDLE;
         line_q       <= '0;
         fl_idx_q     <= '0;
         rd_rsp_valid <= 1'b0;
         rd_rsp_data  <= '0;
         rd_rsp_hit   <= 1'b0;
      end else begin
         rd_rsp_valid <= 1'b0;
         unique case (st_q)
            RD_IDLE: begin
               if (rd_acc) begin
                  line_q <= rd_line;
                  if (rd_fwd) begin
                     rd_rsp_valid <= 1'b1;
                     rd_rsp_data  <= data_q[r_idx];
                     rd_rsp_hit   <= 1'b1;
                  end else if (rd_flush) begin
                     fl_idx_q <= r_idx;
                     st_q     <= RD_FLUSH;
                  end else begin
                     st_q <= RD_MEMRD;
                  end
               end
            end
            RD_FLUSH: if (mem_req_ready) st_q <= RD_MEMRD;
            RD_MEMRD: if (mem_req_ready) st_q <= RD_WAIT;
            RD_WAIT: begin
               if (mem_rsp_valid) begin
                  rd_rsp_valid <= 1'b1;
                  rd_rsp_data  <= mem_rsp_data;
                  rd_rsp_hit   <= 1'b0;
                  st_q         <= RD_IDLE;
               end
            end
            default: st_q <= RD_IDLE;
         endcase
      end
   end

   // memory port: flush, then read, then background drain
   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_write = 1'b1;
      mem_req_line  = tag_q[emit_idx];
      mem_req_data  = data_q[emit_idx];
      mem_req_be    = mask_q[emit_idx];
      unique case (st_q)
         RD_FLUSH: mem_req_valid = 1'b1;
         RD_MEMRD: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b0;
            mem_req_line  = line_q;
            mem_req_be    = '0;
         end
         default: mem_req_valid = drain_ok && o_any;
      endcase
   end

endmodule

// File: rtl/wbuf_cam_chk.sv
module wbuf_cam_chk
   import wbuf_pkg::*;
#(
   parameter int ENTRIES = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               wr_valid,
   input logic               wr_ready,
   input logic               rd_valid,
   input logic               rd_ready,
   input logic               rd_src,
   input logic               rd_rsp_valid,
   input logic               rd_rsp_hit,
   input logic               mem_req_valid,
   input logic               mem_req_write,
   input logic [ENTRIES-1:0] vld_q,
   input logic [ENTRIES-1:0] w_hit,
   input logic [ENTRIES-1:0] r_hit,
   input logic [ENTRIES-1:0] o_vec,
   input logic               r_full,
   input logic               wr_hold,
   input rd_st_e             st_q
);

   // R1
   reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (vld_q == '0) && rd_ready && !rd_rsp_valid && !mem_req_valid);

   // R3
   one_entry_per_line_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(w_hit) && $onehot0(r_hit));

   // R4
   full_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready && !wr_hold) |-> ($countones(vld_q) == ENTRIES));

   // R2
   cpu_forward_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && rd_ready && (rd_src == SRC_CPU) && r_full) |=> (rd_rsp_valid && rd_rsp_hit));

   // R6
   flush_is_write_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == RD_FLUSH) |-> (mem_req_valid && mem_req_write));

   // R5
   miss_is_read_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == RD_MEMRD) |-> (mem_req_valid && !mem_req_write));

   // R8
   single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(o_vec) && ((vld_q != '0) == (o_vec != '0)));

endmodule

bind wbuf_cam wbuf_cam_chk #(.ENTRIES(ENTRIES)) u_wbuf_cam_chk (
   .clk(clk), .rst(rst),
   .wr_valid(wr_valid), .wr_ready(wr_ready),
   .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_src(rd_src),
   .rd_rsp_valid(rd_rsp_valid), .rd_rsp_hit(rd_rsp_hit),
   .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
   .vld_q(vld_q), .w_hit(w_hit), .r_hit(r_hit), .o_vec(o_vec),
   .r_full(r_full), .wr_hold(wr_hold), .st_q(st_q)
);

// File: tb/wbuf_cam_bench.sv
module wbuf_cam_bench;
   import wbuf_pkg::*;

   localparam int N  = 16;
   localparam int LB = 64;
   localparam int AW = 26;
   localparam int LW = LB * 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic          wr_valid = 1'b0, wr_ready;
   logic [AW-1:0] wr_line = '0;
   logic [LW-1:0] wr_data = '0;
   logic [LB-1:0] wr_be = '0;
   logic          rd_valid = 1'b0, rd_ready;
   logic [AW-1:0] rd_line = '0;
   logic          rd_src = 1'b0;
   logic          rd_rsp_valid, rd_rsp_hit;
   logic [LW-1:0] rd_rsp_data;
   logic          mem_req_valid, mem_req_write;
   logic          mem_req_ready = 1'b0;
   logic [AW-1:0] mem_req_line;
   logic [LW-1:0] mem_req_data;
   logic [LB-1:0] mem_req_be;
   logic          mem_rsp_valid = 1'b0;
   logic [LW-1:0] mem_rsp_data = '0;

   wbuf_cam #(.ENTRIES(N), .LINE_BYTES(LB), .LADDR_W(AW)) u_wbuf_cam (
      .clk(clk), .rst(rst),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line),
      .wr_data(wr_data), .wr_be(wr_be),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_line(rd_line), .rd_src(rd_src),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_hit(rd_rsp_hit),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_line(mem_req_line),
      .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // reference state
   logic [LW-1:0] gold [int];
   logic [LW-1:0] memm [int];
   logic [LW-1:0] exp_data [$];
   bit            exp_hit  [$];
   string         exp_rq   [$];
   int            log_line [$];
   bit            log_wr   [$];
   logic [LB-1:0] log_be   [$];

   bit            pend = 1'b0;
   logic [LW-1:0] pdata = '0;

   localparam logic [LB-1:0] BE_ALL = '1;
   localparam logic [LB-1:0] BE_LO  = {{(LB/2){1'b0}}, {(LB/2){1'b1}}};
   localparam logic [LB-1:0] BE_HI  = {{(LB/2){1'b1}}, {(LB/2){1'b0}}};
   localparam logic [LB-1:0] BE_B8  = {{(LB-8){1'b0}}, 8'hFF};

   task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] init_line(int a);
      logic [LW-1:0] v;
      for (int k = 0; k < LW/32; k++) v[k*32 +: 32] = (a * 32'h0100_0193) ^ (k * 32'h9E37_79B9);
      return v;
   endfunction

   function automatic logic [LW-1:0] pat(int s);
      logic [LW-1:0] v;
      for (int k = 0; k < LW/32; k++) v[k*32 +: 32] = (s * 32'h0001_0001) + k + 32'h5A00_0000;
      return v;
   endfunction

   function automatic logic [LW-1:0] gget(int a);
      return gold.exists(a) ? gold[a] : init_line(a);
   endfunction

   function automatic logic [LW-1:0] mget(int a);
      return memm.exists(a) ? memm[a] : init_line(a);
   endfunction

   function automatic logic [LW-1:0] merge(logic [LW-1:0] old, logic [LW-1:0] d, logic [LB-1:0] be);
      logic [LW-1:0] v = old;
      for (int b = 0; b < LB; b++) if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
      return v;
   endfunction

   // monitor: memory model, request log and response scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (!rst) begin
            mem_rsp_valid = pend;
            mem_rsp_data  = pend ? pdata : '0;
            pend          = 1'b0;
            if (mem_req_valid && mem_req_ready) begin
               log_line.push_back(int'(mem_req_line));
               log_wr.push_back(mem_req_write);
               log_be.push_back(mem_req_be);
               if (mem_req_write) begin
                  memm[int'(mem_req_line)] = merge(mget(int'(mem_req_line)), mem_req_data, mem_req_be);
               end else begin
                  pend  = 1'b1;
                  pdata = mget(int'(mem_req_line));
               end
            end
            if (rd_rsp_valid) begin
               if (exp_data.size() == 0) begin
                  check(1'b0, "R2", "unexpected read response", 64'd1, 64'd0);
               end else begin
                  logic [LW-1:0] d;
                  bit            h;
                  string         rq;
                  d  = exp_data.pop_front();
                  h  = exp_hit.pop_front();
                  rq = exp_rq.pop_front();
                  check(rd_rsp_data == d, rq, "read data", rd_rsp_data[63:0], d[63:0]);
                  check(rd_rsp_hit == h, rq, "hit flag", 64'(rd_rsp_hit), 64'(h));
               end
            end
         end
      end
   end

   task automatic do_wr(int line, logic [LW-1:0] d, logic [LB-1:0] be, string rq);
      int t = 0;
      @(negedge clk);
      wr_valid = 1'b1;
      wr_line  = AW'(line);
      wr_data  = d;
      wr_be    = be;
      #2;
      while (!wr_ready && t < 60) begin
         @(negedge clk);
         #2;
         t++;
      end
      check(wr_ready, rq, "write accepted", 64'(t), 64'd0);
      if (wr_ready) gold[line] = merge(gget(line), d, be);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic do_rd(int line, logic src, bit hit, bit open, string rq);
      int t = 0;
      @(negedge clk);
      rd_valid = 1'b1;
      rd_line  = AW'(line);
      rd_src   = src;
      if (open) mem_req_ready = 1'b1;
      #2;
      while (!rd_ready && t < 60) begin
         @(negedge clk);
         #2;
         t++;
      end
      check(rd_ready, rq, "read accepted", 64'(t), 64'd0);
      if (rd_ready) begin
         exp_data.push_back(gget(line));
         exp_hit.push_back(hit);
         exp_rq.push_back(rq);
      end
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic wait_rsp(string rq);
      int t = 0;
      while (exp_data.size() != 0 && t < 300) begin
         @(negedge clk);
         t++;
      end
      check(exp_data.size() == 0, rq, "responses outstanding", 64'(exp_data.size()), 64'd0);
   endtask

   task automatic wait_log(int n, string rq);
      int t = 0;
      while (log_line.size() < n && t < 300) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      check(log_line.size() == n, rq, "memory request count", 64'(log_line.size()), 64'(n));
   endtask

   task automatic check_log(int k, int line, bit wr, string rq);
      bit ok = (log_line.size() > k) && (log_line[k] == line) && (log_wr[k] == wr);
      check(ok, rq, $sformatf("memory request %0d line/write", k),
            (log_line.size() > k) ? 64'({log_line[k], 7'd0, log_wr[k]}) : 64'hDEAD,
            64'({line, 7'd0, wr}));
   endtask

   task automatic clear_log();
      log_line.delete();
      log_wr.delete();
      log_be.delete();
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_up();
   end

   localparam int LA = 'h011, LB_ = 'h022, LC = 'h033, LD = 'h044, LE = 'h055;
   localparam int LF = 'h066, LG = 'h077, LH = 'h100, LX = 'h200;

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;

      // R1: state right after reset
      @(negedge clk);
      #2;
      check(wr_ready == 1'b1, "R1", "wr_ready", 64'(wr_ready), 64'd1);
      check(rd_ready == 1'b1, "R1", "rd_ready", 64'(rd_ready), 64'd1);
      check(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
      check(rd_rsp_valid == 1'b0, "R1", "rd_rsp_valid", 64'(rd_rsp_valid), 64'd0);

      // R2: processor hit on a full line, memory closed
      clear_log();
      do_wr(LB_, pat(1), BE_ALL, "R2");
      do_wr(LA, pat(2), BE_ALL, "R2");
      do_rd(LA, SRC_CPU, 1'b1, 1'b0, "R2");
      wait_rsp("R2");
      check(log_line.size() == 0, "R2", "memory requests on hit", 64'(log_line.size()), 64'd0);

      // R3: byte-enable merge into an existing entry
      do_wr(LA, pat(3), BE_LO, "R3");
      do_rd(LA, SRC_CPU, 1'b1, 1'b0, "R3");
      wait_rsp("R3");
      check(log_line.size() == 0, "R3", "memory requests on merged hit", 64'(log_line.size()), 64'd0);

      // R6 / R9: inbound hit on the younger line flushes it ahead of the older one
      do_rd(LA, SRC_IO, 1'b0, 1'b1, "R6");
      wait_rsp("R6");
      wait_log(3, "R9");
      check_log(0, LA, 1'b1, "R9");
      check(log_be.size() > 0 && log_be[0] == BE_ALL, "R6", "flush byte mask",
            (log_be.size() > 0) ? log_be[0][63:0] : 64'hDEAD, BE_ALL[63:0]);
      check_log(1, LA, 1'b0, "R6");
      check_log(2, LB_, 1'b1, "R8");

      // R5 / R8: miss bypasses buffered writes, which then leave oldest first
      @(negedge clk);
      mem_req_ready = 1'b0;
      clear_log();
      do_wr(LC, pat(4), BE_ALL, "R5");
      do_wr(LD, pat(5), BE_ALL, "R5");
      do_rd(LE, SRC_CPU, 1'b0, 1'b1, "R5");
      wait_rsp("R5");
      wait_log(3, "R5");
      check_log(0, LE, 1'b0, "R5");
      check_log(1, LC, 1'b1, "R8");
      check_log(2, LD, 1'b1, "R8");

      // R10: write accepted after a stalled read to the same line
      @(negedge clk);
      mem_req_ready = 1'b0;
      clear_log();
      do_rd(LF, SRC_IO, 1'b0, 1'b0, "R10");
      do_wr(LF, pat(6), BE_ALL, "R10");
      @(negedge clk);
      mem_req_ready = 1'b1;
      wait_rsp("R10");
      wait_log(2, "R10");
      check_log(0, LF, 1'b0, "R10");
      check_log(1, LF, 1'b1, "R10");
      do_rd(LF, SRC_CPU, 1'b0, 1'b1, "R10");
      wait_rsp("R10");

      // R7: processor hit on a partly written line goes through memory
      @(negedge clk);
      mem_req_ready = 1'b0;
      clear_log();
      do_wr(LG, pat(7), BE_B8, "R7");
      do_rd(LG, SRC_CPU, 1'b0, 1'b1, "R7");
      wait_rsp("R7");
      wait_log(2, "R7");
      check_log(0, LG, 1'b1, "R7");
      check(log_be.size() > 0 && log_be[0] == BE_B8, "R7", "partial flush mask",
            (log_be.size() > 0) ? log_be[0][63:0] : 64'hDEAD, BE_B8[63:0]);
      check_log(1, LG, 1'b0, "R7");

      // R4 / R3 / R8: fill every entry, stall a new line, merge still allowed
      @(negedge clk);
      mem_req_ready = 1'b0;
      clear_log();
      for (int i = 0; i < N; i++) do_wr(LH + i, pat(16 + i), BE_ALL, "R4");
      @(negedge clk);
      wr_valid = 1'b1;
      wr_line  = AW'(LX);
      wr_data  = pat(40);
      wr_be    = BE_ALL;
      for (int c = 0; c < 3; c++) begin
         #2;
         check(wr_ready == 1'b0, "R4", "wr_ready when full", 64'(wr_ready), 64'd0);
         @(negedge clk);
      end
      wr_valid = 1'b0;
      do_wr(LH + 5, pat(41), BE_HI, "R3");
      do_rd(LH + 5, SRC_CPU, 1'b1, 1'b0, "R3");
      wait_rsp("R3");
      @(negedge clk);
      mem_req_ready = 1'b1;
      wait_log(N, "R8");
      for (int i = 0; i < N; i++) check_log(i, LH + i, 1'b1, "R8");
      do_wr(LX, pat(40), BE_ALL, "R4");
      wait_log(N + 1, "R8");
      check_log(N, LX, 1'b1, "R8");
      do_rd(LH + 5, SRC_CPU, 1'b0, 1'b1, "R3");
      do_rd(LX, SRC_CPU, 1'b0, 1'b1, "R4");
      wait_rsp("R4");

      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule